// File: doc/BRIEF.md
# Reconfigurable 16-bit Timer/Counter with Capture

This block is one 16-bit counting resource that splits into two 8-bit halves or joins them into a single wide counter, depending on a 2-bit mode input. A shared 8-bit prescaler divides an instruction-cycle enable pulse. Each counter either counts prescaler ticks or counts rising edges of a synchronized external event input. Each half has a match value. When a count reaches its match value it returns to zero and raises a sticky interrupt flag.

Two capture strobes copy the running count into capture registers. In the split modes each strobe serves its own half. In the wide modes the low strobe takes all 16 bits in one cycle and the high strobe does nothing. The prescaler tick is also brought out so that another timer can use it as its clock.

Top module: `split_timer`

## Requirements
- R1: After reset, both capture outputs, both interrupt flags and the prescaler tick are zero.
- R2: `preTick` is high only in a cycle where `cycEn` is high. It is high on every (`preLoad`+1)-th `cycEn` pulse, the first one being pulse number `preLoad`+1 after reset.
- R3: With `modeSel`=0, the low and high halves each count prescaler ticks as independent 8-bit counters, each compared against its own match value.
- R4: With `modeSel`=1, the low half counts prescaler ticks and the high half counts rising edges of `evtIn`. Event counting does not wait for `cycEn`, and events do not change the low half.
- R5: With `modeSel`=2, the halves form one 16-bit counter of prescaler ticks {high,low}, compared against {`matchHi`,`matchLo`}.
- R6: With `modeSel`=3, the halves form one 16-bit counter of `evtIn` rising edges. `cycEn` pulses do not change it.
- R7: When an increment arrives while a count equals its match value, the count becomes zero instead of incrementing. That wrap sets `irqLo` or `irqHi` for the half concerned in the split modes, and sets only `irqHi` in the wide modes.
- R8: An interrupt flag stays set until a one-cycle pulse on its clear input. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R9: In the split modes, `capLoStb` copies the low count into `capLo` and `capHiStb` copies the high count into `capHi`. The value taken is the count as it stood before any increment in that same cycle.
- R10: In the wide modes, `capLoStb` copies both halves at once into `capHi` and `capLo`, and `capHiStb` alone leaves both capture outputs unchanged.
- R11: An event pulse that is high for one clock and followed by one clock low is counted once per rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycEn | input | 1 | One pulse per instruction cycle |
| evtIn | input | 1 | Synchronized external event level |
| capLoStb | input | 1 | Low-half capture strobe (all 16 bits in wide modes) |
| capHiStb | input | 1 | High-half capture strobe (split modes only) |
| modeSel | input | 2 | 0 split ticks, 1 ticks low/events high, 2 wide ticks, 3 wide events |
| preLoad | input | 8 | Prescaler terminal value (divide by preLoad+1) |
| matchLo | input | 8 | Low-half match value |
| matchHi | input | 8 | High-half match value |
| clrLo | input | 1 | Write-one pulse clearing irqLo |
| clrHi | input | 1 | Write-one pulse clearing irqHi |
| capLo | output | 8 | Low capture register |
| capHi | output | 8 | High capture register |
| irqLo | output | 1 | Low-half sticky match flag |
| irqHi | output | 1 | High-half (or wide) sticky match flag |
| preTick | output | 1 | Prescaler output tick |

## Verification
A capture strobe can arrive in the very cycle in which the count wraps from its match value to zero. The bench lines up a capture strobe with the increment that hits the match value. It expects the captured value to be the match value, the flag to be set, and a second capture to read zero. A flag clear pulse can also coincide with a wrap. The bench sets the match value to zero so that every increment wraps, drives the clear and the increment together, and expects the flag to remain set.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT    = 2'd0,
    MODE_MIXED    = 2'd1,
    MODE_WIDE_TMR = 2'd2,
    MODE_WIDE_EVT = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic incLo;  // advance low (or wide) counter
    logic incHi;  // advance high counter (split modes)
    logic wide;   // halves chained
    logic capLo;  // capture low half (both when wide)
    logic capHi;  // capture high half (split only)
  } tmrStb_t;
endpackage

// File: rtl/split_timer_ctrl.sv
module split_timer_ctrl
  import split_timer_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycEn,
  input  logic             evtIn,
  input  logic             capLoStb,
  input  logic             capHiStb,
  input  logic [1:0]       modeSel,
  input  logic [PRE_W-1:0] preLoad,
  output tmrStb_t          stb,
  output logic             preTick
);
  logic [PRE_W-1:0] preCnt;
  logic             preTerm;
  logic             evtPrev;
  logic             evtRise;
  tmrMode_e         mode;

  assign preTerm = (preCnt >= preLoad);
  assign preTick = cycEn && preTerm;
  assign evtRise = evtIn && !evtPrev;
  assign mode    = tmrMode_e'(modeSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      evtPrev <= 1'b0;
    end else begin
      evtPrev <= evtIn;
      if (cycEn) preCnt <= preTerm ? '0 : preCnt + 1'b1;
    end
  end

  always_comb begin
    stb = '0;
    unique case (mode)
      MODE_SPLIT: begin
        stb.incLo = preTick;
        stb.incHi = preTick;
      end
      MODE_MIXED: begin
        stb.incLo = preTick;
        stb.incHi = evtRise;
      end
      MODE_WIDE_TMR: begin
        stb.incLo = preTick;
        stb.wide  = 1'b1;
      end
      MODE_WIDE_EVT: begin
        stb.incLo = evtRise;
        stb.wide  = 1'b1;
      end
      default: stb = '0;
    endcase
    stb.capLo = capLoStb;
    stb.capHi = capHiStb && !stb.wide;
  end

  AST_TICK_ON_EN: assert property (@(posedge clk) disable iff (!rstN)
    preTick |-> cycEn); // R2
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (preTick && $stable(preLoad) && preLoad != '0) |=> !preTick); // R2
endmodule

// File: rtl/split_timer_dp.sv
module split_timer_dp
  import split_timer_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStb_t           stb,
  input  logic [HALF_W-1:0] matchLo,
  input  logic [HALF_W-1:0] matchHi,
  input  logic              clrLo,
  input  logic              clrHi,
  output logic [HALF_W-1:0] capLo,
  output logic [HALF_W-1:0] capHi,
  output logic              irqLo,
  output logic              irqHi
);
  localparam int FULL_W = 2 * HALF_W;
  localparam int NHALF  = 2;

  logic [HALF_W-1:0] cnt     [NHALF];
  logic [HALF_W-1:0] cntNext [NHALF];
  logic [HALF_W-1:0] capQ    [NHALF];
  logic [HALF_W-1:0] matchV  [NHALF];
  logic [NHALF-1:0]  inc, hit, setIrq, clrIrq, capEn, irqQ;
  logic [FULL_W-1:0] wideCnt, wideMatch, wideNext;
  logic              wideHit;

  assign matchV[0] = matchLo;
  assign matchV[1] = matchHi;
  assign inc       = {stb.incHi, stb.incLo};
  assign clrIrq    = {clrHi, clrLo};
  assign capEn     = {stb.capHi | (stb.capLo & stb.wide), stb.capLo};
  assign wideCnt   = {cnt[1], cnt[0]};
  assign wideMatch = {matchHi, matchLo};
  assign wideHit   = (wideCnt == wideMatch);
  assign wideNext  = wideHit ? '0 : wideCnt + 1'b1;

  for (genvar g = 0; g < NHALF; g++) begin : g_half
    assign hit[g] = (cnt[g] == matchV[g]);
  end

  always_comb begin
    setIrq = '0;
    for (int h = 0; h < NHALF; h++) cntNext[h] = cnt[h];
    if (stb.wide) begin
      if (stb.incLo) begin
        {cntNext[1], cntNext[0]} = wideNext;
        setIrq[1] = wideHit;
      end
    end else begin
      for (int h = 0; h < NHALF; h++) begin
        if (inc[h]) begin
          cntNext[h] = hit[h] ? '0 : cnt[h] + 1'b1;
          setIrq[h]  = hit[h];
        end
      end
    end
  end

  for (genvar g = 0; g < NHALF; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt[g]  <= '0;
        capQ[g] <= '0;
        irqQ[g] <= 1'b0;
      end else begin
        cnt[g]  <= cntNext[g];
        if (capEn[g]) capQ[g] <= cnt[g];
        irqQ[g] <= (irqQ[g] && !clrIrq[g]) || setIrq[g];
      end
    end
  end

  assign capLo = capQ[0];
  assign capHi = capQ[1];
  assign irqLo = irqQ[0];
  assign irqHi = irqQ[1];

  AST_WRAP_LO: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wide && stb.incLo && cnt[0] == matchLo) |=> (cnt[0] == '0 && irqLo)); // R7
  AST_FLAG_STICKY_LO: assert property (@(posedge clk) disable iff (!rstN)
    (irqLo && !clrLo) |=> irqLo); // R8
  AST_FLAG_STICKY_HI: assert property (@(posedge clk) disable iff (!rstN)
    (irqHi && !clrHi) |=> irqHi); // R8
  AST_WIDE_HI_CAP_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wide && !stb.capLo) |=> ($stable(capHi) && $stable(capLo))); // R10
  AST_WIDE_NO_LO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wide && !irqLo) |=> !irqLo); // R7
endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycEn,
  input  logic              evtIn,
  input  logic              capLoStb,
  input  logic              capHiStb,
  input  logic [1:0]        modeSel,
  input  logic [PRE_W-1:0]  preLoad,
  input  logic [HALF_W-1:0] matchLo,
  input  logic [HALF_W-1:0] matchHi,
  input  logic              clrLo,
  input  logic              clrHi,
  output logic [HALF_W-1:0] capLo,
  output logic [HALF_W-1:0] capHi,
  output logic              irqLo,
  output logic              irqHi,
  output logic              preTick
);
  tmrStb_t stb;

  split_timer_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycEn(cycEn), .evtIn(evtIn),
    .capLoStb(capLoStb), .capHiStb(capHiStb), .modeSel(modeSel),
    .preLoad(preLoad), .stb(stb), .preTick(preTick)
  );

  split_timer_dp #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .matchLo(matchLo), .matchHi(matchHi),
    .clrLo(clrLo), .clrHi(clrHi), .capLo(capLo), .capHi(capHi),
    .irqLo(irqLo), .irqHi(irqHi)
  );
endmodule

// File: tb/split_timer_tb.sv
module split_timer_tb;
  logic       clk = 1'b0;
  logic       rstN, cycEn, evtIn, capLoStb, capHiStb, clrLo, clrHi;
  logic [1:0] modeSel;
  logic [7:0] preLoad, matchLo, matchHi;
  logic [7:0] capLo, capHi;
  logic       irqLo, irqHi, preTick;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  split_timer u_dut (
    .clk(clk), .rstN(rstN), .cycEn(cycEn), .evtIn(evtIn),
    .capLoStb(capLoStb), .capHiStb(capHiStb), .modeSel(modeSel),
    .preLoad(preLoad), .matchLo(matchLo), .matchHi(matchHi),
    .clrLo(clrLo), .clrHi(clrHi), .capLo(capLo), .capHi(capHi),
    .irqLo(irqLo), .irqHi(irqHi), .preTick(preTick)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [1:0] m, input logic [7:0] pl,
                         input logic [7:0] ml, input logic [7:0] mh);
    @(negedge clk);
    rstN = 1'b0; cycEn = 1'b0; evtIn = 1'b0; capLoStb = 1'b0; capHiStb = 1'b0;
    clrLo = 1'b0; clrHi = 1'b0;
    modeSel = m; preLoad = pl; matchLo = ml; matchHi = mh;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseEn(input int n);
    for (int i = 0; i < n; i++) begin
      cycEn = 1'b1; @(negedge clk);
      cycEn = 1'b0; @(negedge clk); @(negedge clk);
    end
  endtask

  task automatic evtPulses(input int n);
    for (int i = 0; i < n; i++) begin
      evtIn = 1'b1; @(negedge clk);
      evtIn = 1'b0; @(negedge clk);
    end
  endtask

  task automatic capBoth();
    capLoStb = 1'b1; capHiStb = 1'b1; @(negedge clk);
    capLoStb = 1'b0; capHiStb = 1'b0; @(negedge clk);
  endtask

  task automatic testReset();
    doReset(2'd0, 8'd3, 8'd9, 8'd9);
    chk("R1 capLo", {8'h0, capLo}, 16'h0);
    chk("R1 capHi", {8'h0, capHi}, 16'h0);
    chk("R1 irq", {14'h0, irqHi, irqLo}, 16'h0);
    chk("R1 preTick", {15'h0, preTick}, 16'h0);
  endtask

  task automatic testPrescaler();
    int ticks = 0;
    int first = 0;
    doReset(2'd0, 8'd2, 8'hFF, 8'hFF);
    for (int i = 1; i <= 9; i++) begin
      cycEn = 1'b1; #1;
      if (preTick) begin ticks++; if (first == 0) first = i; end
      @(negedge clk); cycEn = 1'b0; #1;
      if (preTick) ticks = ticks + 100;
      @(negedge clk); @(negedge clk);
    end
    chk("R2 tick count", 16'(ticks), 16'd3);
    chk("R2 first tick", 16'(first), 16'd3);
  endtask

  task automatic testSplit();
    doReset(2'd0, 8'd0, 8'd4, 8'd200);
    pulseEn(5);
    capBoth();
    chk("R3 low wrapped", {8'h0, capLo}, 16'd0);
    chk("R3 high count", {8'h0, capHi}, 16'd5);
    chk("R7 irqLo set", {15'h0, irqLo}, 16'd1);
    chk("R7 irqHi clear", {15'h0, irqHi}, 16'd0);
  endtask

  task automatic testMixed();
    doReset(2'd1, 8'd1, 8'hFF, 8'hFF);
    pulseEn(6);
    evtPulses(5);
    capBoth();
    chk("R4 low ticks", {8'h0, capLo}, 16'd3);
    chk("R4 R11 high events", {8'h0, capHi}, 16'd5);
  endtask

  task automatic testWideTmr();
    doReset(2'd2, 8'd0, 8'h05, 8'h01);
    pulseEn(260);
    capLoStb = 1'b1; @(negedge clk); capLoStb = 1'b0; @(negedge clk);
    chk("R5 wide low", {8'h0, capLo}, 16'h04);
    chk("R5 wide high", {8'h0, capHi}, 16'h01);
    pulseEn(1);
    capHiStb = 1'b1; @(negedge clk); capHiStb = 1'b0; @(negedge clk);
    chk("R10 hi strobe ignored", {capHi, capLo}, 16'h0104);
    chk("R7 no wrap yet", {14'h0, irqHi, irqLo}, 16'h0);
    pulseEn(1);
    capLoStb = 1'b1; @(negedge clk); capLoStb = 1'b0; @(negedge clk);
    chk("R7 wide wrapped", {capHi, capLo}, 16'h0000);
    chk("R7 wide sets irqHi only", {14'h0, irqHi, irqLo}, 16'h2);
  endtask

  task automatic testWideEvt();
    doReset(2'd3, 8'd0, 8'hFF, 8'hFF);
    evtPulses(300);
    pulseEn(4);
    capLoStb = 1'b1; @(negedge clk); capLoStb = 1'b0; @(negedge clk);
    chk("R6 R10 wide events", {capHi, capLo}, 16'h012C);
  endtask

  task automatic testSticky();
    doReset(2'd0, 8'd0, 8'd0, 8'hFF);
    pulseEn(1);
    repeat (5) @(negedge clk);
    chk("R8 flag holds", {15'h0, irqLo}, 16'd1);
    clrLo = 1'b1; @(negedge clk); clrLo = 1'b0; @(negedge clk);
    chk("R8 flag cleared", {15'h0, irqLo}, 16'd0);
    cycEn = 1'b1; clrLo = 1'b1; @(negedge clk);
    cycEn = 1'b0; clrLo = 1'b0; @(negedge clk);
    chk("R8 set wins over clear", {15'h0, irqLo}, 16'd1);
  endtask

  task automatic testCapAtWrap();
    doReset(2'd0, 8'd0, 8'd2, 8'hFF);
    pulseEn(2);
    cycEn = 1'b1; capLoStb = 1'b1; @(negedge clk);
    cycEn = 1'b0; capLoStb = 1'b0; @(negedge clk);
    chk("R9 capture before wrap", {8'h0, capLo}, 16'd2);
    chk("R9 wrap flag", {15'h0, irqLo}, 16'd1);
    capLoStb = 1'b1; @(negedge clk); capLoStb = 1'b0; @(negedge clk);
    chk("R9 count after wrap", {8'h0, capLo}, 16'd0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    testReset();
    testPrescaler();
    testSplit();
    testMixed();
    testWideTmr();
    testWideEvt();
    testSticky();
    testCapAtWrap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule